// File: doc/BRIEF.md
# Three-Channel Count-Up Watchdog

The block holds three independent watchdog channels behind one 32-bit register port. Each channel has a counter that counts up on every reference tick and a reset threshold. Software keeps the system alive by writing a low value into the counter before it reaches the threshold. When a channel's reset enable is set and its counter has reached or passed its threshold, the channel raises a reset request. Channel 0 drives a recovery-mode reset request. Channels 1 and 2 share a normal system reset request.

Channel 0 also has an interrupt threshold, an interrupt enable and a sticky status flag. The flag is set while the enable is on and the counter is at or above the interrupt threshold. It stays set until software writes a one to it, and the interrupt pin shows the flag gated by the enable. Registers are read combinationally. Writes take effect at the clock edge.

Top module: `tri_wdog`

## Requirements
- R1: After reset, every counter, threshold, enable and status bit is 0, all reads return 0 and all three outputs are low. The reset is asynchronous and active low.
- R2: On a clock edge with `tick_en` high, each channel counter increases by one and wraps from 0xFFFFFFFF to 0. Without a tick the counter holds its value.
- R3: A register write to a counter loads the written value at that edge, even when a tick arrives in the same cycle.
- R4: A channel requests reset while its reset enable is 1 and its counter is greater than or equal to its reset threshold, compared as 32-bit unsigned values. Channel 0 drives `rec_rst_req`. Channels 1 and 2 drive `sys_rst_req` through an OR. The request follows the register contents combinationally.
- R5: Setting the reset enable, then writing 0 to the threshold and 0 to the counter, gives a request as soon as those writes have landed.
- R6: With the reset enable at 0, the counter keeps running and a counter at or above its threshold raises no request.
- R7: On the edge after any cycle in which the channel 0 interrupt enable is 1 and its counter is at or above its interrupt threshold, the channel 0 status bit becomes 1. It holds until cleared. `wdog_irq` equals enable AND status.
- R8: Writing control with bit 1 = 1 clears the channel 0 status bit. Writing 0 in bit 1 leaves it unchanged. A set condition in the same cycle wins over the clear.
- R9: The following are unmapped: offsets with channel field 3, the interrupt-threshold slot of channels 1 and 2, and any address whose low two bits are not 0. Reads of unmapped addresses return 0, and writes to them change nothing.
- R10: The byte address bits [5:4] select the channel and bits [3:2] select the register: 0 = counter, 1 = reset threshold, 2 = interrupt threshold (channel 0 only), 3 = control. Control bit 0 is interrupt enable, bit 1 is status (write-one-to-clear) and bit 2 is reset enable. Channels 1 and 2 read bits 0 and 1 as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Reference tick, one cycle wide per count |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| wdog_irq | output | 1 | Channel 0 interrupt |
| rec_rst_req | output | 1 | Recovery-mode reset request from channel 0 |
| sys_rst_req | output | 1 | Normal reset request from channels 1 and 2 |

## Verification
Two cases are hard to reach from the ports. The first is the counter wrap, which would take four billion ticks; the bench instead writes 0xFFFFFFFF and applies one tick. The second is the one-cycle gap between the interrupt condition and the sticky status flag, which the bench pins down by checking the pins in the cycle just after the counter reaches the threshold and again one cycle later. The same-edge write-versus-tick race and the unsigned compare against a threshold with its top bit set are both driven directly from the vector table.

// File: rtl/tri_wdog_pkg.sv
package tri_wdog_pkg;

    // datapath and map geometry
    localparam int unsigned DW       = 32;
    localparam int unsigned N_CH     = 3;
    localparam int unsigned AW       = 6;
    localparam int unsigned SLOT_LSB = 2;
    localparam int unsigned CH_LSB   = 4;
    localparam int unsigned CH_W     = AW - CH_LSB;
    localparam int unsigned IRQ_CH   = 0;

    // control bit positions (decoded by software)
    localparam int unsigned IE_BIT = 0;
    localparam int unsigned ST_BIT = 1;
    localparam int unsigned RE_BIT = 2;
    localparam int unsigned CTL_W  = 3;

    typedef enum logic [1:0] {
        SLOT_CNT  = 2'd0,
        SLOT_RTHR = 2'd1,
        SLOT_ITHR = 2'd2,
        SLOT_CTRL = 2'd3
    } slot_e;

    typedef struct packed {
        logic [DW-1:0] cnt;
        logic [DW-1:0] rthr;
        logic [DW-1:0] ithr;
        logic          ie;
        logic          st;
        logic          re;
    } chan_state_t;

endpackage

// File: rtl/wdog_regif.sv
module wdog_regif
    import tri_wdog_pkg::*;
(
    input  logic                        reg_wr,
    input  logic [AW-1:0]               reg_addr,
    input  logic [N_CH-1:0][DW-1:0]     ch_cnt,
    input  logic [N_CH-1:0][DW-1:0]     ch_rthr,
    input  logic [N_CH-1:0][DW-1:0]     ch_ithr,
    input  logic [N_CH-1:0][CTL_W-1:0]  ch_ctrl,
    output logic [N_CH-1:0]             wr_cnt,
    output logic [N_CH-1:0]             wr_rthr,
    output logic [N_CH-1:0]             wr_ithr,
    output logic [N_CH-1:0]             wr_ctrl,
    output logic [DW-1:0]               reg_rdata
);

    logic            aligned;
    logic [CH_W-1:0] ch_idx;
    slot_e           slot;
    logic [N_CH-1:0] ch_sel;

    assign aligned = (reg_addr[SLOT_LSB-1:0] == '0);
    assign ch_idx  = reg_addr[AW-1:CH_LSB];
    assign slot    = slot_e'(reg_addr[CH_LSB-1:SLOT_LSB]);

    for (genvar c = 0; c < N_CH; c++) begin : g_dec
        assign ch_sel[c]  = aligned && (ch_idx == CH_W'(c));
        assign wr_cnt[c]  = reg_wr && ch_sel[c] && (slot == SLOT_CNT);
        assign wr_rthr[c] = reg_wr && ch_sel[c] && (slot == SLOT_RTHR);
        assign wr_ctrl[c] = reg_wr && ch_sel[c] && (slot == SLOT_CTRL);
        if (c == IRQ_CH) begin : g_ithr
            assign wr_ithr[c] = reg_wr && ch_sel[c] && (slot == SLOT_ITHR);
        end else begin : g_no_ithr
            assign wr_ithr[c] = 1'b0;
        end
    end

    // read mux: unmapped slots fall through to zero
    always_comb begin
        reg_rdata = '0;
        for (int c = 0; c < N_CH; c++) begin
            if (ch_sel[c]) begin
                unique case (slot)
                    SLOT_CNT:  reg_rdata = ch_cnt[c];
                    SLOT_RTHR: reg_rdata = ch_rthr[c];
                    SLOT_ITHR: reg_rdata = (c == IRQ_CH) ? ch_ithr[c] : '0;
                    SLOT_CTRL: reg_rdata = DW'(ch_ctrl[c]);
                    default:   reg_rdata = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/wdog_channel.sv
module wdog_channel
    import tri_wdog_pkg::*;
#(
    parameter bit HAS_IRQ = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             wr_cnt,
    input  logic             wr_rthr,
    input  logic             wr_ithr,
    input  logic             wr_ctrl,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    cnt_o,
    output logic [DW-1:0]    rthr_o,
    output logic [DW-1:0]    ithr_o,
    output logic [CTL_W-1:0] ctrl_o,
    output logic             rst_req_o,
    output logic             irq_o
);

    chan_state_t s_d, s_q;
    logic        rst_hit;
    logic        irq_hit;
    logic        st_clr;

    // unsigned compares against the registered counter
    assign rst_hit = s_q.re && (s_q.cnt >= s_q.rthr);
    assign irq_hit = s_q.ie && (s_q.cnt >= s_q.ithr);
    assign st_clr  = wr_ctrl && wdata[ST_BIT];

    always_comb begin
        s_d = s_q;

        // software load beats the tick
        if (wr_cnt) begin
            s_d.cnt = wdata;
        end else if (tick_en) begin
            s_d.cnt = s_q.cnt + DW'(1);
        end

        if (wr_rthr) begin
            s_d.rthr = wdata;
        end
        if (wr_ctrl) begin
            s_d.re = wdata[RE_BIT];
        end

        if (HAS_IRQ) begin
            if (wr_ithr) begin
                s_d.ithr = wdata;
            end
            if (wr_ctrl) begin
                s_d.ie = wdata[IE_BIT];
            end
            // sticky flag: set beats clear
            s_d.st = (s_q.st && !st_clr) || irq_hit;
        end else begin
            s_d.ithr = '0;
            s_d.ie   = 1'b0;
            s_d.st   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        ctrl_o         = '0;
        ctrl_o[IE_BIT] = s_q.ie;
        ctrl_o[ST_BIT] = s_q.st;
        ctrl_o[RE_BIT] = s_q.re;
    end

    assign cnt_o     = s_q.cnt;
    assign rthr_o    = s_q.rthr;
    assign ithr_o    = s_q.ithr;
    assign rst_req_o = rst_hit;
    assign irq_o     = s_q.ie && s_q.st;

endmodule

// File: rtl/tri_wdog.sv
module tri_wdog
    import tri_wdog_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          wdog_irq,
    output logic          rec_rst_req,
    output logic          sys_rst_req
);

    logic [N_CH-1:0]            wr_cnt;
    logic [N_CH-1:0]            wr_rthr;
    logic [N_CH-1:0]            wr_ithr;
    logic [N_CH-1:0]            wr_ctrl;
    logic [N_CH-1:0][DW-1:0]    ch_cnt;
    logic [N_CH-1:0][DW-1:0]    ch_rthr;
    logic [N_CH-1:0][DW-1:0]    ch_ithr;
    logic [N_CH-1:0][CTL_W-1:0] ch_ctrl;
    logic [N_CH-1:0]            ch_rst;
    logic [N_CH-1:0]            ch_irq;

    wdog_regif u_regif (
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .ch_cnt    (ch_cnt),
        .ch_rthr   (ch_rthr),
        .ch_ithr   (ch_ithr),
        .ch_ctrl   (ch_ctrl),
        .wr_cnt    (wr_cnt),
        .wr_rthr   (wr_rthr),
        .wr_ithr   (wr_ithr),
        .wr_ctrl   (wr_ctrl),
        .reg_rdata (reg_rdata)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        wdog_channel #(
            .HAS_IRQ (c == IRQ_CH)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick_en   (tick_en),
            .wr_cnt    (wr_cnt[c]),
            .wr_rthr   (wr_rthr[c]),
            .wr_ithr   (wr_ithr[c]),
            .wr_ctrl   (wr_ctrl[c]),
            .wdata     (reg_wdata),
            .cnt_o     (ch_cnt[c]),
            .rthr_o    (ch_rthr[c]),
            .ithr_o    (ch_ithr[c]),
            .ctrl_o    (ch_ctrl[c]),
            .rst_req_o (ch_rst[c]),
            .irq_o     (ch_irq[c])
        );
    end

    // channel 0 -> recovery, the rest -> normal reset
    assign rec_rst_req = ch_rst[0];
    assign sys_rst_req = |ch_rst[N_CH-1:1];
    assign wdog_irq    = ch_irq[IRQ_CH];

endmodule

// File: rtl/wdog_chk.sv
module wdog_chk
    import tri_wdog_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic [DW-1:0]    reg_wdata,
    input logic             wr_cnt0,
    input logic             wr_ctrl0,
    input logic [DW-1:0]    cnt0,
    input logic [DW-1:0]    ithr0,
    input logic [CTL_W-1:0] ctrl0,
    input logic [CTL_W-1:0] ctrl1,
    input logic [CTL_W-1:0] ctrl2,
    input logic             irq,
    input logic             sys_req
);

    // R2
    cnt_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !wr_cnt0) |=> (cnt0 == DW'($past(cnt0) + DW'(1))));

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !wr_cnt0) |=> $stable(cnt0));

    // R3
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt0 |=> (cnt0 == $past(reg_wdata)));

    // R6
    sys_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl1[RE_BIT] && !ctrl2[RE_BIT]) |-> !sys_req);

    // R7
    st_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl0[IE_BIT] && (cnt0 >= ithr0)) |=> ctrl0[ST_BIT]);

    // R7
    st_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl0[ST_BIT] && !(wr_ctrl0 && reg_wdata[ST_BIT])) |=> ctrl0[ST_BIT]);

    // R7
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ctrl0[ST_BIT] && ctrl0[IE_BIT]));

    // R8
    st_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl0 && reg_wdata[ST_BIT] && !(ctrl0[IE_BIT] && (cnt0 >= ithr0)))
        |=> !ctrl0[ST_BIT]);

    // R10
    ch_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl1[ST_BIT:IE_BIT] == 2'b00) && (ctrl2[ST_BIT:IE_BIT] == 2'b00));

endmodule

bind tri_wdog wdog_chk u_wdog_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .reg_wdata (reg_wdata),
    .wr_cnt0   (wr_cnt[0]),
    .wr_ctrl0  (wr_ctrl[0]),
    .cnt0      (ch_cnt[0]),
    .ithr0     (ch_ithr[0]),
    .ctrl0     (ch_ctrl[0]),
    .ctrl1     (ch_ctrl[1]),
    .ctrl2     (ch_ctrl[2]),
    .irq       (wdog_irq),
    .sys_req   (sys_rst_req)
);

// File: tb/test_tri_wdog.sv
module test_tri_wdog;

    // op codes: WR write, RD read-compare, TK tick, CK pins compare, WT write+tick
    localparam logic [2:0] OP_WR = 3'd0;
    localparam logic [2:0] OP_RD = 3'd1;
    localparam logic [2:0] OP_TK = 3'd2;
    localparam logic [2:0] OP_CK = 3'd3;
    localparam logic [2:0] OP_WT = 3'd4;
    localparam int         NV    = 64;

    // pins compare value: bit2 wdog_irq, bit1 sys_rst_req, bit0 rec_rst_req
    // vector = {op, requirement, address, data, expected}
    localparam logic [76:0] VECS [0:NV-1] = '{
        {OP_RD, 4'd1,  6'h00, 32'd0, 32'd0},                 // R1
        {OP_RD, 4'd1,  6'h0C, 32'd0, 32'd0},                 // R1
        {OP_CK, 4'd1,  6'h00, 32'd0, 32'd0},                 // R1
        {OP_WR, 4'd10, 6'h04, 32'd5, 32'd0},
        {OP_RD, 4'd10, 6'h04, 32'd0, 32'd5},                 // R10
        {OP_WR, 4'd2,  6'h00, 32'd3, 32'd0},
        {OP_TK, 4'd2,  6'h00, 32'd0, 32'd0},
        {OP_TK, 4'd2,  6'h00, 32'd0, 32'd0},
        {OP_RD, 4'd2,  6'h00, 32'd0, 32'd5},                 // R2
        {OP_CK, 4'd6,  6'h00, 32'd0, 32'd0},                 // R6
        {OP_WR, 4'd4,  6'h0C, 32'd4, 32'd0},
        {OP_CK, 4'd4,  6'h00, 32'd0, 32'd1},                 // R4 ch0
        {OP_WR, 4'd4,  6'h00, 32'd0, 32'd0},
        {OP_CK, 4'd4,  6'h00, 32'd0, 32'd0},                 // R4 kick
        {OP_WR, 4'd6,  6'h0C, 32'd0, 32'd0},
        {OP_WR, 4'd6,  6'h00, 32'd7, 32'd0},
        {OP_CK, 4'd6,  6'h00, 32'd0, 32'd0},                 // R6
        {OP_RD, 4'd3,  6'h00, 32'd0, 32'd7},                 // R3
        {OP_WR, 4'd5,  6'h14, 32'd0, 32'd0},
        {OP_WR, 4'd5,  6'h1C, 32'd4, 32'd0},
        {OP_WR, 4'd5,  6'h10, 32'd0, 32'd0},
        {OP_CK, 4'd5,  6'h00, 32'd0, 32'd2},                 // R5
        {OP_WR, 4'd4,  6'h14, 32'h8000_0000, 32'd0},
        {OP_WR, 4'd4,  6'h10, 32'h0000_0010, 32'd0},
        {OP_CK, 4'd4,  6'h00, 32'd0, 32'd0},                 // R4 unsigned
        {OP_WR, 4'd4,  6'h10, 32'hFFFF_FFFF, 32'd0},
        {OP_CK, 4'd4,  6'h00, 32'd0, 32'd2},                 // R4 unsigned
        {OP_TK, 4'd2,  6'h00, 32'd0, 32'd0},
        {OP_RD, 4'd2,  6'h10, 32'd0, 32'd0},                 // R2 wrap
        {OP_CK, 4'd2,  6'h00, 32'd0, 32'd0},
        {OP_WR, 4'd4,  6'h24, 32'd2, 32'd0},
        {OP_WR, 4'd4,  6'h2C, 32'd4, 32'd0},
        {OP_WR, 4'd4,  6'h20, 32'd1, 32'd0},
        {OP_CK, 4'd4,  6'h00, 32'd0, 32'd0},
        {OP_TK, 4'd4,  6'h00, 32'd0, 32'd0},
        {OP_CK, 4'd4,  6'h00, 32'd0, 32'd2},                 // R4 ch2
        {OP_RD, 4'd10, 6'h2C, 32'd0, 32'd4},                 // R10
        {OP_WR, 4'd6,  6'h2C, 32'd0, 32'd0},
        {OP_CK, 4'd6,  6'h00, 32'd0, 32'd0},                 // R6
        {OP_WT, 4'd3,  6'h20, 32'd100, 32'd0},
        {OP_RD, 4'd3,  6'h20, 32'd0, 32'd100},               // R3
        {OP_WR, 4'd7,  6'h08, 32'd3, 32'd0},
        {OP_WR, 4'd7,  6'h00, 32'd2, 32'd0},
        {OP_WR, 4'd7,  6'h0C, 32'd1, 32'd0},
        {OP_CK, 4'd7,  6'h00, 32'd0, 32'd0},
        {OP_TK, 4'd7,  6'h00, 32'd0, 32'd0},
        {OP_CK, 4'd7,  6'h00, 32'd0, 32'd0},                 // R7 one-cycle gap
        {OP_CK, 4'd7,  6'h00, 32'd0, 32'd4},                 // R7
        {OP_WR, 4'd7,  6'h00, 32'd0, 32'd0},
        {OP_CK, 4'd7,  6'h00, 32'd0, 32'd4},                 // R7 sticky
        {OP_RD, 4'd10, 6'h0C, 32'd0, 32'd3},
        {OP_WR, 4'd8,  6'h0C, 32'd1, 32'd0},
        {OP_RD, 4'd8,  6'h0C, 32'd0, 32'd3},                 // R8 zero keeps
        {OP_WR, 4'd8,  6'h0C, 32'd3, 32'd0},
        {OP_RD, 4'd8,  6'h0C, 32'd0, 32'd1},                 // R8 clear
        {OP_CK, 4'd8,  6'h00, 32'd0, 32'd0},
        {OP_WR, 4'd7,  6'h00, 32'd9, 32'd0},
        {OP_RD, 4'd7,  6'h0C, 32'd0, 32'd1},
        {OP_RD, 4'd7,  6'h0C, 32'd0, 32'd3},                 // R7
        {OP_WR, 4'd7,  6'h0C, 32'd0, 32'd0},
        {OP_RD, 4'd7,  6'h0C, 32'd0, 32'd2},                 // R7
        {OP_CK, 4'd7,  6'h00, 32'd0, 32'd0},                 // R7 irq gated
        {OP_WR, 4'd8,  6'h0C, 32'd2, 32'd0},
        {OP_RD, 4'd8,  6'h0C, 32'd0, 32'd0}                  // R8
    };

    logic        clk;
    logic        rst_n;
    logic        tick_en;
    logic        reg_wr;
    logic [5:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        wdog_irq;
    logic        rec_rst_req;
    logic        sys_rst_req;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    tri_wdog i_tri_wdog (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_en     (tick_en),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .wdog_irq    (wdog_irq),
        .rec_rst_req (rec_rst_req),
        .sys_rst_req (sys_rst_req)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] op, input logic [3:0] req,
                          input logic [5:0] a, input logic [31:0] d,
                          input logic [31:0] e);
        @(negedge clk);
        reg_wr    = (op == OP_WR) || (op == OP_WT);
        tick_en   = (op == OP_TK) || (op == OP_WT);
        reg_addr  = a;
        reg_wdata = d;
        #1;
        if (op == OP_RD) begin
            check(int'(req), reg_rdata, e);
        end else if (op == OP_CK) begin
            check(int'(req), {29'd0, wdog_irq, sys_rst_req, rec_rst_req}, e);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        rst_n     = 1'b0;
        tick_en   = 1'b0;
        reg_wr    = 1'b0;
        reg_addr  = '0;
        reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run_op(VECS[i][76:74], VECS[i][73:70], VECS[i][69:64],
                   VECS[i][63:32], VECS[i][31:0]);
        end

        // R9 unmapped slots and misaligned addresses
        run_op(OP_WR, 4'd9, 6'h18, 32'h0000_DEAD, 32'd0);
        run_op(OP_RD, 4'd9, 6'h18, 32'd0, 32'd0);
        run_op(OP_RD, 4'd9, 6'h14, 32'd0, 32'h8000_0000);
        run_op(OP_WR, 4'd9, 6'h30, 32'd5, 32'd0);
        run_op(OP_RD, 4'd9, 6'h30, 32'd0, 32'd0);
        run_op(OP_WR, 4'd9, 6'h01, 32'hFF, 32'd0);
        run_op(OP_RD, 4'd9, 6'h00, 32'd0, 32'd9);
        run_op(OP_RD, 4'd9, 6'h01, 32'd0, 32'd0);
        run_op(OP_RD, 4'd9, 6'h28, 32'd0, 32'd0);

        // R10 channel 1 has no interrupt bits
        run_op(OP_WR, 4'd10, 6'h1C, 32'd7, 32'd0);
        run_op(OP_RD, 4'd10, 6'h1C, 32'd0, 32'd4);

        // R1 asynchronous reset while a request is active
        run_op(OP_WR, 4'd5, 6'h14, 32'd0, 32'd0);
        run_op(OP_CK, 4'd5, 6'h00, 32'd0, 32'd2);
        @(negedge clk);
        reg_wr  = 1'b0;
        tick_en = 1'b0;
        rst_n   = 1'b0;
        #1;
        check(1, {29'd0, wdog_irq, sys_rst_req, rec_rst_req}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        run_op(OP_RD, 4'd1, 6'h14, 32'd0, 32'd0);
        run_op(OP_RD, 4'd1, 6'h1C, 32'd0, 32'd0);
        run_op(OP_RD, 4'd1, 6'h00, 32'd0, 32'd0);

        @(negedge clk);
        reg_wr  = 1'b0;
        tick_en = 1'b0;
        done    = 1'b1;
        finish_run();
    end

endmodule